// File: doc/BRIEF.md
# Dual-Rail Handshake Pipeline Stage

This block is one stage of an elastic pipeline that carries words in a dual-rail code, modelled with a clock. Each logical bit travels on a pair of wires: `rail1` and `rail0`. A pair with both wires low is the spacer, meaning no data. `rail1` high with `rail0` low stands for a one. `rail0` high with `rail1` low stands for a zero. Both wires high is never a legal code. Validity therefore travels inside the data itself. Every channel also has a single acknowledge wire, and the stage follows a four-phase return-to-spacer handshake on both sides.

The stage watches the upstream word. When its acknowledge is low, every bit pair carries a value, and its own output slot is free, it captures the whole word and raises the upstream acknowledge. It keeps that acknowledge high until every upstream pair has returned to the spacer. It offers the captured word downstream and holds it until the downstream acknowledge rises. It then emits an all-spacer word, and it accepts no new data until the downstream acknowledge has fallen again. An illegal both-high pair on the input sets a sticky error flag.

A binary-to-dual-rail encoder and a decoder of the held word are included so that a test can make round trips between plain binary and the rail code.

Top module: `dr_stage`

## Requirements
- R1: After reset, `up_ack` is 0, both downstream rail vectors are all zero (spacer), `proto_err` is 0 and `dec_valid` is 0.
- R2: When `up_ack` is low, every upstream pair is valid ({rail1,rail0} = 10 for one, 01 for zero), the output is spacer and `dn_ack` is low, then at the next clock edge the downstream rails take the upstream rails and `up_ack` goes high.
- R3: A word in which any pair is both-low is not captured: the output stays spacer and `up_ack` stays low.
- R4: `up_ack` stays high while any upstream pair is non-spacer, and it goes low at the first clock edge at which all upstream pairs are both-low.
- R5: While `up_ack` is high, a change of the upstream word is not captured, and the downstream rails keep the held word.
- R6: The held word stays on the downstream rails until `dn_ack` is high. At the edge where it is seen high, the output becomes all-spacer.
- R7: No new word is captured while the output holds data or while `dn_ack` is high, even when the upstream word is complete and `up_ack` is low.
- R8: Any upstream pair seen as both-high sets `proto_err` at the next edge. The flag stays set until reset, and a word that contains such a pair is not captured.
- R9: The encoder drives `enc_r1` = `enc_bin` and `enc_r0` = ~`enc_bin` combinationally. `dec_bin` is the binary value of the held word, and `dec_valid` is high exactly when the downstream word is complete.
- R10: The downstream rails never show a both-high pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_r1 | input | W | Upstream rail1 (one) wires |
| up_r0 | input | W | Upstream rail0 (zero) wires |
| up_ack | output | 1 | Acknowledge to upstream |
| dn_r1 | output | W | Downstream rail1 wires |
| dn_r0 | output | W | Downstream rail0 wires |
| dn_ack | input | 1 | Acknowledge from downstream |
| proto_err | output | 1 | Sticky illegal-code flag |
| enc_bin | input | W | Binary word to encode |
| enc_r1 | output | W | Encoded rail1 wires |
| enc_r0 | output | W | Encoded rail0 wires |
| dec_bin | output | W | Binary value of the held word |
| dec_valid | output | 1 | Held word is complete |

## Verification
Each change of the handshake or data state takes effect one clock edge after the input that causes it. This covers capture together with the `up_ack` rise, the `up_ack` fall after the spacer, the move to spacer after `dn_ack`, and the setting of `proto_err`. The encoder output and `dec_bin`/`dec_valid` follow their sources within the same cycle. The bench changes inputs on the falling edge, steps one rising edge, and samples on the next falling edge. Combinational results are therefore read in the same half cycle, and registered results exactly one edge later. Holding and ignoring cases are checked by sampling again after further edges with the blocking condition still present.

// File: rtl/dr_pkg.sv
package dr_pkg;

    localparam int DATA_W = 8;

    // pair code as {rail1, rail0}
    typedef enum logic [1:0] {
        PAIR_NULL = 2'b00,
        PAIR_ZERO = 2'b01,
        PAIR_ONE  = 2'b10,
        PAIR_BAD  = 2'b11
    } pair_e;

    function automatic pair_e classify(input logic r1, input logic r0);
        return pair_e'({r1, r0});
    endfunction

    function automatic logic [1:0] encode_bit(input logic b);
        return b ? PAIR_ONE : PAIR_ZERO;
    endfunction

endpackage

// File: rtl/dr_detect.sv
module dr_detect
    import dr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r0,
    output logic         all_valid,
    output logic         all_null,
    output logic         any_bad
);
    logic [W-1:0] v, n, b;

    for (genvar i = 0; i < W; i++) begin : g_pair
        pair_e code;
        assign code = classify(r1[i], r0[i]);
        assign v[i] = (code == PAIR_ZERO) || (code == PAIR_ONE);
        assign n[i] = (code == PAIR_NULL);
        assign b[i] = (code == PAIR_BAD);
    end

    assign all_valid = &v;
    assign all_null  = &n;
    assign any_bad   = |b;
endmodule

// File: rtl/dr_encode.sv
module dr_encode
    import dr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] bin,
    output logic [W-1:0] r1,
    output logic [W-1:0] r0
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign {r1[i], r0[i]} = encode_bit(bin[i]);
    end
endmodule

// File: rtl/dr_decode.sv
module dr_decode
    import dr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r0,
    output logic [W-1:0] bin
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = (classify(r1[i], r0[i]) == PAIR_ONE);
    end
endmodule

// File: rtl/dr_stage.sv
module dr_stage
    import dr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] up_r1,
    input  logic [W-1:0] up_r0,
    output logic         up_ack,
    output logic [W-1:0] dn_r1,
    output logic [W-1:0] dn_r0,
    input  logic         dn_ack,
    output logic         proto_err,
    input  logic [W-1:0] enc_bin,
    output logic [W-1:0] enc_r1,
    output logic [W-1:0] enc_r0,
    output logic [W-1:0] dec_bin,
    output logic         dec_valid
);
    logic [W-1:0] hold_r1, hold_r0;
    logic         ack_q, err_q;
    logic         up_valid, up_null, up_bad;
    logic         dn_full, dn_empty, dn_bad;
    logic         take, release_ack, drain;

    dr_detect #(.W(W)) u_up_det (
        .r1(up_r1), .r0(up_r0),
        .all_valid(up_valid), .all_null(up_null), .any_bad(up_bad)
    );

    dr_detect #(.W(W)) u_dn_det (
        .r1(hold_r1), .r0(hold_r0),
        .all_valid(dn_full), .all_null(dn_empty), .any_bad(dn_bad)
    );

    dr_encode #(.W(W)) u_enc (.bin(enc_bin), .r1(enc_r1), .r0(enc_r0));
    dr_decode #(.W(W)) u_dec (.r1(hold_r1), .r0(hold_r0), .bin(dec_bin));

    assign take        = !ack_q && up_valid && dn_empty && !dn_ack;
    assign release_ack = ack_q && up_null;
    assign drain       = dn_full && dn_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_r1 <= '0;
            hold_r0 <= '0;
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (take) begin
                hold_r1 <= up_r1;
                hold_r0 <= up_r0;
                ack_q   <= 1'b1;
            end else if (release_ack) begin
                ack_q   <= 1'b0;
            end
            if (drain) begin
                hold_r1 <= '0;
                hold_r0 <= '0;
            end
            if (up_bad) err_q <= 1'b1;
        end
    end

    assign up_ack    = ack_q;
    assign dn_r1     = hold_r1;
    assign dn_r0     = hold_r0;
    assign proto_err = err_q;
    assign dec_valid = dn_full;

    // R2
    ack_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(up_ack) |-> dn_full);

    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (up_ack && !up_null) |=> up_ack);

    // R6
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_full && !dn_ack) |=> ($stable(dn_r1) && $stable(dn_r0)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R10
    no_both_high_chk: assert property (@(posedge clk) disable iff (rst)
        !dn_bad);
endmodule

// File: tb/dr_stage_test.sv
module dr_stage_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] up_r1 = '0, up_r0 = '0;
    logic         up_ack, dn_ack = 1'b0, proto_err, dec_valid;
    logic [W-1:0] dn_r1, dn_r0, enc_bin = '0, enc_r1, enc_r0, dec_bin;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dr_stage #(.W(W)) uut (
        .clk(clk), .rst(rst), .up_r1(up_r1), .up_r0(up_r0), .up_ack(up_ack),
        .dn_r1(dn_r1), .dn_r0(dn_r0), .dn_ack(dn_ack), .proto_err(proto_err),
        .enc_bin(enc_bin), .enc_r1(enc_r1), .enc_r0(enc_r0),
        .dec_bin(dec_bin), .dec_valid(dec_valid)
    );

    // {value, mask of bits held at spacer for a partial first offer}
    localparam logic [15:0] VEC [6] = '{
        16'h00_00, 16'hFF_01, 16'hA5_80, 16'h5A_00, 16'h01_10, 16'h80_FF
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_word(input logic [W-1:0] v, input logic [W-1:0] drop);
        up_r1 = v & ~drop;
        up_r0 = ~v & ~drop;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check(up_ack == 0, "R1 up_ack", up_ack, 0);
        check(dn_r1 == 0 && dn_r0 == 0, "R1 spacer out", {dn_r1, dn_r0}, 0);
        check(proto_err == 0, "R1 proto_err", proto_err, 0);
        check(dec_valid == 0, "R1 dec_valid", dec_valid, 0);

        foreach (VEC[k]) begin
            logic [W-1:0] v, m;
            v = VEC[k][15:8];
            m = VEC[k][7:0];
            enc_bin = v;
            #1;
            // R9 encoder
            check(enc_r1 == v && enc_r0 == ~v, "R9 encode", {enc_r1, enc_r0}, {v, ~v});
            if (m != 0) begin
                drive_word(v, m);
                step();
                // R3 partial word ignored
                check(up_ack == 0 && dn_r1 == 0 && dn_r0 == 0, "R3 partial",
                      {up_ack, dn_r1, dn_r0}, 0);
            end
            drive_word(v, '0);
            step();
            // R2 capture
            check(up_ack == 1 && dn_r1 == v && dn_r0 == ~v, "R2 capture",
                  {up_ack, dn_r1, dn_r0}, {1'b1, v, ~v});
            // R9 round trip
            check(dec_bin == v && dec_valid == 1, "R9 decode", {dec_valid, dec_bin}, {1'b1, v});
            dn_ack = 1'b1;
            step();
            // R6 drain to spacer
            check(dn_r1 == 0 && dn_r0 == 0 && dec_valid == 0, "R6 drain",
                  {dn_r1, dn_r0}, 0);
            // R4 ack held while data present
            check(up_ack == 1, "R4 hold", up_ack, 1);
            drive_word('0, '1);
            step();
            check(up_ack == 0, "R4 release", up_ack, 0);
            dn_ack = 1'b0;
            step();
        end

        // R5 ack high: new word not taken
        drive_word(8'h3C, '0);
        step();
        drive_word(8'hC3, '0);
        step();
        check(dn_r1 == 8'h3C && dn_r0 == 8'hC3, "R5 no recapture", dn_r1, 8'h3C);
        // R6 held without ack
        step();
        check(dn_r1 == 8'h3C && up_ack == 1, "R6 held", dn_r1, 8'h3C);
        // R7 output full blocks capture
        drive_word('0, '1);
        step();
        drive_word(8'h77, '0);
        step();
        check(up_ack == 0 && dn_r1 == 8'h3C, "R7 full blocks", {up_ack, dn_r1}, {1'b0, 8'h3C});
        dn_ack = 1'b1;
        step();
        step();
        // R7 dn_ack high blocks capture
        check(up_ack == 0 && dn_r1 == 0 && dn_r0 == 0, "R7 ack blocks",
              {up_ack, dn_r1, dn_r0}, 0);
        dn_ack = 1'b0;
        step();
        check(up_ack == 1 && dn_r1 == 8'h77, "R7 capture after ack low",
              {up_ack, dn_r1}, {1'b1, 8'h77});
        dn_ack = 1'b1;
        drive_word('0, '1);
        step();
        step();
        dn_ack = 1'b0;
        step();

        // R8 illegal pair
        drive_word(8'h12, '0);
        up_r0[7] = 1'b1;
        up_r1[7] = 1'b1;
        step();
        check(proto_err == 1, "R8 err set", proto_err, 1);
        check(up_ack == 0 && dn_r1 == 0 && dn_r0 == 0, "R8 no capture",
              {up_ack, dn_r1, dn_r0}, 0);
        drive_word('0, '1);
        step();
        step();
        check(proto_err == 1, "R8 sticky", proto_err, 1);
        // R10 output never both-high across the run
        check((dn_r1 & dn_r0) == 0, "R10 rails", dn_r1 & dn_r0, 0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        check(proto_err == 0, "R1 err cleared", proto_err, 0);

        finish_run();
    end
endmodule